// File: doc/BRIEF.md
# Audio Frame and Bit Clock Generator

This block is the clock source for an audio converter that drives its own serial port. Running entirely on the master clock, it produces a frame clock (one period per sample, low for the first half-frame and high for the second) and a bit clock, both derived by counting master-clock cycles. Both outputs are therefore synchronous to the master clock. A speed-mode input selects single, double or quad speed. For each speed there is a ratio select for the master-to-frame ratio and another for the bit-to-frame ratio. An optional divide-by-two prescaler sits in front of all of the counting logic.

Configuration inputs are sampled only at a frame boundary, so a running frame always completes with the settings it started with. A configuration that the selected speed does not allow, or the reserved speed code, stops both clocks low and raises an error flag. The next legal configuration restarts the clocks on the following master tick.

Top module: `aclk_gen`

## Requirements
- R1: While rst_n is low, lrck_o, sclk_o and cfg_err_o are all low at every clock edge.
- R2: speed_mode 00 is single speed, 01 is double speed, 10 is quad speed. mclk_ratio_sel picks the frame length in master cycles: single 0→256, 1→512; double 0→128, 1→256; quad 0→128. One lrck_o period lasts exactly that many clk cycles.
- R3: sclk_ratio_sel 00 selects 64 bit clocks per frame (the default), 01 selects 32 and 10 selects 128. 128 is allowed only in single speed. Each frame holds exactly that many sclk_o rising edges.
- R4: lrck_o is low for the first half of each frame and high for the second half, and it changes level only in the cycle where sclk_o falls.
- R5: With mclk_div2 high, every derived period doubles: one frame lasts twice the R2 count of clk cycles, with the same bit clocks per frame.
- R6: speed_mode 11, sclk_ratio_sel 11, sclk_ratio_sel 10 outside single speed, and mclk_ratio_sel 1 in quad speed are illegal. Once such a setting takes effect, cfg_err_o is high and lrck_o and sclk_o stay low. With a legal setting in effect, cfg_err_o is low.
- R7: A change on any configuration input takes effect only at the next frame boundary. The frame in progress keeps its length and cfg_err_o keeps its value until then.
- R8: While stopped in error, a legal configuration is taken up within three clk cycles, which clears cfg_err_o and restarts the frame from its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_mode | input | 2 | Speed select: 00 single, 01 double, 10 quad, 11 reserved |
| mclk_div2 | input | 1 | 1 halves the master clock ahead of all counting |
| mclk_ratio_sel | input | 1 | Picks the lower (0) or higher (1) master-to-frame ratio of the speed |
| sclk_ratio_sel | input | 2 | Bit clocks per frame: 00→64, 01→32, 10→128, 11 illegal |
| lrck_o | output | 1 | Frame clock, low for the first half-frame |
| sclk_o | output | 1 | Bit clock |
| cfg_err_o | output | 1 | High while an illegal configuration is in effect |

## Verification
Several properties are checked on every cycle by the assertions. The frame clock moves only on a falling bit-clock edge. An active error keeps both clocks low and the frame counter parked. The latched configuration never changes in the middle of a frame. With the prescaler on, master ticks never arrive back to back. Other behaviour can only be shown by the bench's scenarios, because it is a count over a whole frame rather than a relation between neighbouring cycles. These are the actual frame length for every legal ratio, the number of bit clocks per frame, the half-frame duty and the doubling under the prescaler. The bench also checks that a mid-frame change leaves the running frame untouched and how quickly the block recovers from an error.

// File: rtl/aclk_pkg.sv
// Shared constants and types for the audio clock generator.
// Assumes the largest master-to-frame ratio is 2**MLOG_MAX.
package aclk_pkg;

    parameter int MLOG_MAX = 9;                 // log2 of the largest frame length
    parameter int CNT_W    = MLOG_MAX;          // frame counter width
    parameter int IDX_W    = $clog2(CNT_W);     // width of a bit index into the counter

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    // Decoded configuration as the counter consumes it
    typedef struct packed {
        logic             div2;     // prescaler on
        logic [IDX_W-1:0] lr_bit;   // counter bit that forms the frame clock
        logic [IDX_W-1:0] bc_bit;   // counter bit that forms the bit clock
    } clk_cfg_t;

endpackage

// File: rtl/aclk_cfg_decode.sv
// Configuration decoder: turns the raw speed and ratio selects into
// counter bit indices and a legality flag. Purely combinational.
// Assumes every legal combination gives at least two master ticks per bit clock.
module aclk_cfg_decode
    import aclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  speed_mode,
    input  logic        mclk_div2,
    input  logic        mclk_ratio_sel,
    input  logic [1:0]  sclk_ratio_sel,
    output clk_cfg_t    cfg_o,
    output logic        legal_o
);

    logic [IDX_W-1:0] m_log;    // log2 of master ticks per frame
    logic [IDX_W-1:0] s_log;    // log2 of bit clocks per frame
    logic             ok;

    // Decode ratios and legality of the requested combination
    always_comb begin
        m_log = '0;
        s_log = '0;
        ok    = 1'b1;
        case (sclk_ratio_sel)
            2'b00:   s_log = IDX_W'(6);
            2'b01:   s_log = IDX_W'(5);
            2'b10:   s_log = IDX_W'(7);
            default: ok = 1'b0;
        endcase
        case (speed_e'(speed_mode))
            SPD_SINGLE: m_log = mclk_ratio_sel ? IDX_W'(9) : IDX_W'(8);
            SPD_DOUBLE: begin
                m_log = mclk_ratio_sel ? IDX_W'(8) : IDX_W'(7);
                if (sclk_ratio_sel == 2'b10) ok = 1'b0;
            end
            SPD_QUAD: begin
                m_log = IDX_W'(7);
                if (mclk_ratio_sel || sclk_ratio_sel == 2'b10) ok = 1'b0;
            end
            default: ok = 1'b0;
        endcase
    end

    // Form the counter bit indices; zero them when illegal
    always_comb begin
        cfg_o.div2   = mclk_div2;
        cfg_o.lr_bit = ok ? m_log - IDX_W'(1) : '0;
        cfg_o.bc_bit = ok ? m_log - s_log - IDX_W'(1) : '0;
        legal_o      = ok;
    end

    // R3: a legal setting always leaves at least two master ticks per bit clock
    a_r3_ratio_min: assert property (@(posedge clk) disable iff (!rst_n)
        legal_o |-> (m_log > s_log));

endmodule

// File: rtl/aclk_prescale.sv
// Master tick generator: passes every clk cycle as a tick, or every
// second one when the active configuration enables the divide-by-two.
// Assumes div2_i changes only in a cycle that carried a tick.
module aclk_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic div2_i,
    output logic tick_o
);

    logic phase_q;

    // Toggle the phase while dividing, park it at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= 1'b0;
        else if (div2_i) phase_q <= ~phase_q;
        else             phase_q <= 1'b0;
    end

    assign tick_o = !div2_i || phase_q;

    // R5: with the prescaler on, ticks never fall in adjacent cycles
    a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (div2_i && tick_o) |=> (!tick_o || !div2_i));

endmodule

// File: rtl/aclk_frame_ctr.sv
// Frame counter: counts master ticks over one frame and latches a new
// configuration only at a frame boundary. While the latched setting is
// illegal (or nothing is latched yet) every tick is a boundary, so a
// legal setting is picked up on the next tick.
module aclk_frame_ctr
    import aclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  clk_cfg_t         cfg_i,
    input  logic             legal_i,
    output clk_cfg_t         act_o,
    output logic             act_legal_o,
    output logic             loaded_o,
    output logic [CNT_W-1:0] cnt_o
);

    clk_cfg_t         act_q;
    logic             legal_q;
    logic             loaded_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             boundary;

    // Last count of a frame: all ones up to and including the frame-clock bit
    always_comb begin
        for (int i = 0; i < CNT_W; i++)
            last_cnt[i] = (IDX_W'(i) <= act_q.lr_bit);
    end

    assign boundary = !loaded_q || !legal_q || (cnt_q == last_cnt);

    // Advance the counter per tick; reload the configuration at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            legal_q  <= 1'b0;
            loaded_q <= 1'b0;
            cnt_q    <= '0;
        end else if (tick_i) begin
            if (boundary) begin
                act_q    <= cfg_i;
                legal_q  <= legal_i;
                loaded_q <= 1'b1;
                cnt_q    <= '0;
            end else begin
                cnt_q    <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign act_o       = act_q;
    assign act_legal_o = legal_q;
    assign loaded_o    = loaded_q;
    assign cnt_o       = cnt_q;

    // R7: the latched configuration is stable anywhere inside a frame
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $stable(act_q));

    // R2: the counter never passes the last count of the frame
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt);

    // R6: an illegal setting parks the counter
    a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && !legal_q) |-> (cnt_q == '0));

endmodule

// File: rtl/aclk_out_stage.sv
// Output register: picks the frame and bit clock bits out of the counter
// and registers them together with the error flag, one cycle after the count.
module aclk_out_stage
    import aclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  clk_cfg_t         act_i,
    input  logic             act_legal_i,
    input  logic             loaded_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             lrck_o,
    output logic             sclk_o,
    output logic             err_o
);

    logic run;
    assign run = loaded_i && act_legal_i;

    // Register both clocks and the error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrck_o <= 1'b0;
            sclk_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            lrck_o <= run && cnt_i[act_i.lr_bit];
            sclk_o <= run && cnt_i[act_i.bc_bit];
            err_o  <= loaded_i && !act_legal_i;
        end
    end

    // R4: the frame clock moves only together with a falling bit clock
    a_r4_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (lrck_o != $past(lrck_o)) |-> (!sclk_o && $past(sclk_o)));

    // R6: the error flag keeps both clocks low
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!lrck_o && !sclk_o));

endmodule

// File: rtl/aclk_gen.sv
// Audio frame/bit clock generator top. Chains the configuration decoder,
// the master prescaler, the frame counter and the output register.
// Assumes all inputs are synchronous to clk.
module aclk_gen
    import aclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_mode,
    input  logic       mclk_div2,
    input  logic       mclk_ratio_sel,
    input  logic [1:0] sclk_ratio_sel,
    output logic       lrck_o,
    output logic       sclk_o,
    output logic       cfg_err_o
);

    clk_cfg_t         req_cfg;
    logic             req_legal;
    clk_cfg_t         act_cfg;
    logic             act_legal;
    logic             loaded;
    logic [CNT_W-1:0] cnt;
    logic             tick;

    aclk_cfg_decode u_dec (
        .clk            (clk),
        .rst_n          (rst_n),
        .speed_mode     (speed_mode),
        .mclk_div2      (mclk_div2),
        .mclk_ratio_sel (mclk_ratio_sel),
        .sclk_ratio_sel (sclk_ratio_sel),
        .cfg_o          (req_cfg),
        .legal_o        (req_legal)
    );

    aclk_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .div2_i (act_cfg.div2),
        .tick_o (tick)
    );

    aclk_frame_ctr u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .cfg_i       (req_cfg),
        .legal_i     (req_legal),
        .act_o       (act_cfg),
        .act_legal_o (act_legal),
        .loaded_o    (loaded),
        .cnt_o       (cnt)
    );

    aclk_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act_cfg),
        .act_legal_i (act_legal),
        .loaded_i    (loaded),
        .cnt_i       (cnt),
        .lrck_o      (lrck_o),
        .sclk_o      (sclk_o),
        .err_o       (cfg_err_o)
    );

endmodule

// File: tb/aclk_gen_tb.sv
// Bench for aclk_gen: directed corner cases plus seeded random settings,
// judged by frame measurements against expected values from functions.
module aclk_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] speed_mode = 2'b00;
    logic       mclk_div2 = 1'b0;
    logic       mclk_ratio_sel = 1'b0;
    logic [1:0] sclk_ratio_sel = 2'b00;
    logic       lrck_o, sclk_o, cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    aclk_gen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .speed_mode     (speed_mode),
        .mclk_div2      (mclk_div2),
        .mclk_ratio_sel (mclk_ratio_sel),
        .sclk_ratio_sel (sclk_ratio_sel),
        .lrck_o         (lrck_o),
        .sclk_o         (sclk_o),
        .cfg_err_o      (cfg_err_o)
    );

    function automatic bit exp_legal(logic [1:0] md, logic ms, logic [1:0] ss);
        if (md == 2'b11 || ss == 2'b11) return 1'b0;
        if (md != 2'b00 && ss == 2'b10) return 1'b0;
        if (md == 2'b10 && ms) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int exp_frame(logic [1:0] md, logic ms, logic dv);
        int m;
        case (md)
            2'b00:   m = ms ? 512 : 256;
            2'b01:   m = ms ? 256 : 128;
            default: m = 128;
        endcase
        return dv ? 2 * m : m;
    endfunction

    function automatic int exp_bits(logic [1:0] ss);
        case (ss)
            2'b00:   return 64;
            2'b01:   return 32;
            default: return 128;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] md, logic ms, logic [1:0] ss, logic dv);
        @(negedge clk);
        speed_mode = md;
        mclk_ratio_sel = ms;
        sclk_ratio_sel = ss;
        mclk_div2 = dv;
    endtask

    // Wait at negedges until lrck_o falls
    task automatic wait_fall();
        logic pl;
        pl = lrck_o;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (pl && !lrck_o) return;
            pl = lrck_o;
        end
    endtask

    // Measure one frame starting just after an lrck_o fall
    task automatic measure(output int len, output int rises, output int hi,
                           output int bad, output int errs);
        logic pl, ps;
        len = 0; rises = 0; hi = 0; bad = 0; errs = 0;
        pl = lrck_o; ps = sclk_o;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            len++;
            if (cfg_err_o) errs++;
            if (!ps && sclk_o) rises++;
            if (lrck_o != pl && !(ps && !sclk_o)) bad++;
            if (lrck_o) hi++;
            if (pl && !lrck_o) break;
            pl = lrck_o; ps = sclk_o;
        end
    endtask

    task automatic run_legal(logic [1:0] md, logic ms, logic [1:0] ss, logic dv);
        int len, rises, hi, bad, errs, f;
        apply(md, ms, ss, dv);
        wait_fall();
        measure(len, rises, hi, bad, errs);
        f = exp_frame(md, ms, dv);
        if (dv) chk(len == f, "R5 frame length with divide", len, f);
        else    chk(len == f, "R2 frame length", len, f);
        chk(rises == exp_bits(ss), "R3 bit clocks per frame", rises, exp_bits(ss));
        chk(hi == f / 2, "R4 half-frame high time", hi, f / 2);
        chk(bad == 0, "R4 lrck moves only on sclk fall", bad, 0);
        chk(errs == 0, "R6 no error on legal setting", errs, 0);
    endtask

    task automatic run_illegal(logic [1:0] md, logic ms, logic [1:0] ss, logic dv);
        int waited, noisy;
        apply(md, ms, ss, dv);
        waited = 0;
        while (!cfg_err_o && waited < 2200) begin
            @(negedge clk);
            waited++;
        end
        chk(cfg_err_o == 1'b1, "R6 error flag raised", cfg_err_o, 1);
        noisy = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (lrck_o || sclk_o || !cfg_err_o) noisy++;
        end
        chk(noisy == 0, "R6 clocks held low in error", noisy, 0);
    endtask

    task automatic run_any(logic [1:0] md, logic ms, logic [1:0] ss, logic dv);
        if (exp_legal(md, ms, ss)) run_legal(md, ms, ss, dv);
        else                       run_illegal(md, ms, ss, dv);
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int len, rises, hi, bad, errs, r;
        logic [1:0] md, ss;
        logic ms, dv;
        r = $urandom(32'd24680);

        // R1: outputs low throughout reset
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!lrck_o && !sclk_o && !cfg_err_o, "R1 reset state",
                {lrck_o, sclk_o, cfg_err_o}, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3 default setting: single speed, 256x, 64 bits
        run_legal(2'b00, 1'b0, 2'b00, 1'b0);
        run_legal(2'b00, 1'b1, 2'b10, 1'b0);   // R3 128 bits at 512x
        run_legal(2'b01, 1'b0, 2'b00, 1'b0);   // R2 double 128x, 2 ticks per bit
        run_legal(2'b10, 1'b0, 2'b01, 1'b0);   // R2 quad 128x, 32 bits
        run_legal(2'b00, 1'b1, 2'b01, 1'b1);   // R5 longest frame with divide
        run_legal(2'b00, 1'b0, 2'b10, 1'b1);   // R5 fastest bit clock, divided

        // R6: each illegal kind
        run_illegal(2'b11, 1'b0, 2'b00, 1'b0);
        run_illegal(2'b01, 1'b0, 2'b10, 1'b0);
        run_illegal(2'b10, 1'b1, 2'b00, 1'b0);
        run_illegal(2'b00, 1'b0, 2'b11, 1'b1);

        // R8: recovery from error within three cycles
        apply(2'b01, 1'b1, 2'b01, 1'b0);
        repeat (3) @(negedge clk);
        chk(cfg_err_o == 1'b0, "R8 error cleared quickly", cfg_err_o, 0);
        wait_fall();
        measure(len, rises, hi, bad, errs);
        chk(len == 256, "R8 restarted frame length", len, 256);

        // R7: mid-frame change keeps the running frame
        run_legal(2'b00, 1'b0, 2'b00, 1'b0);
        repeat (10) @(negedge clk);
        speed_mode = 2'b10; sclk_ratio_sel = 2'b01;
        measure(len, rises, hi, bad, errs);
        chk(len == 256 - 10, "R7 current frame finishes unchanged", len, 246);
        measure(len, rises, hi, bad, errs);
        chk(len == 128 && rises == 32, "R7 new setting after boundary", len, 128);

        // R7: an illegal setting mid-frame waits for the boundary
        run_legal(2'b00, 1'b0, 2'b00, 1'b0);
        repeat (10) @(negedge clk);
        speed_mode = 2'b11;
        repeat (50) @(negedge clk);
        chk(cfg_err_o == 1'b0, "R7 error deferred to boundary", cfg_err_o, 0);
        wait_fall();
        @(negedge clk);
        chk(cfg_err_o == 1'b1, "R7 error after boundary", cfg_err_o, 1);

        // Seeded random settings
        for (int it = 0; it < 20; it++) begin
            md = 2'($urandom % 4);
            ms = 1'($urandom % 2);
            ss = 2'($urandom % 4);
            dv = 1'($urandom % 2);
            run_any(md, ms, ss, dv);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule